// File: doc/BRIEF.md
# Mode-Dependent Eight-Pin I/O Port

This block is an eight-pin I/O port on a simple processor register bus. It holds three registers: a pin direction register, a pin data register and a pull-up select register. A two-bit operating mode and the direction bits decide the role of each pin. A pin can drive the upper address byte, drive the data register bit, act as a general input, or float.

In the address mode, every pin carries the upper address byte, and the direction register is pinned to all ones. In the mixed mode, a pin with its direction bit set drives its upper address bit, and a pin with the bit clear is an input. In the general-purpose mode, a pin with its direction bit set drives its data register bit, and a pin with the bit clear is an input.

There are two standby inputs, and they act differently. Hardware standby floats every pin and clears the direction register. Software standby leaves every register and pin as it is. The upper address byte comes from outside the block, and pin electrical behaviour is not modelled.

Top module: `gpio_modal_port`

## Requirements
- R1: The direction register decodes at 0xFFB1, the data register at 0xFFB3 and the pull-up register at 0xFFAD. A write to any other address changes nothing, and a read from any other address returns 0x00.
- R2: With `op_mode` = 1 (address mode), all eight `pin_oe` bits are 1 and `pin_out` equals `addr_hi`. Direction writes are ignored, and the direction register is loaded with 0xFF on every clock edge spent in this mode.
- R3: With `op_mode` = 2 (mixed mode), a pin whose direction bit is 1 has `pin_oe` = 1 and drives its `addr_hi` bit. A pin whose direction bit is 0 has `pin_oe` = 0 and `pin_out` = 0.
- R4: With `op_mode` = 0 or 3 (general-purpose mode), a pin whose direction bit is 1 has `pin_oe` = 1 and drives its data register bit. A pin whose direction bit is 0 has `pin_oe` = 0 and `pin_out` = 0.
- R5: A read of the direction register returns 0xFF in every mode, whatever the register holds.
- R6: After reset, the direction, data and pull-up registers all hold 0x00.
- R7: While `hw_stby` is 1, every `pin_oe` bit is 0 in the same cycle. Outside address mode, each clock edge during hardware standby clears the direction register, so the pins stay inputs after `hw_stby` returns to 0.
- R8: `sw_stby` has no effect on any register, on `pin_oe`, on `pin_out` or on `pin_pu`. The direction register changes only through a direction write, a clock edge in address mode, or hardware standby.
- R9: The data and pull-up registers are read/write. A write is done when `bus_sel` and `bus_wr` are both 1 at a clock edge, and the new value shows on the outputs after that edge.
- R10: `pin_pu` bit i is 1 only when pull-up bit i is 1, pin i is not driving, and `hw_stby` is 0.
- R11: A read of the data register returns, for each pin, the latched bit if the pin's effective direction is 1, and the `pin_in` level if it is 0.
- R12: `bus_rdata` follows `bus_sel` and `bus_addr` combinationally in the same cycle. It is 0x00 while `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 1 address, 2 mixed, 0/3 general-purpose |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| addr_hi | input | 8 | Upper address byte to drive out |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pin_pu | output | 8 | Pull-up enables |

## Verification
A corrupted direction register is never visible through a read, because reads of it always return all ones. It shows up instead on `pin_oe` in the same cycle. It also shows on the data register readback, which mixes latched bits with `pin_in` according to the direction. A wrong data or pull-up register shows on `pin_out`, `pin_pu` or its own readback one edge after the write. A standby that is mishandled shows either at once on `pin_oe`, or one edge after release as pins that still drive.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [1:0] {
    OPM_ADDR,
    OPM_MIXED,
    OPM_GPIO
  } op_mode_e;

  function automatic op_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd1:    decode_mode = OPM_ADDR;
      2'd2:    decode_mode = OPM_MIXED;
      default: decode_mode = OPM_GPIO;
    endcase
  endfunction
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
  import iop_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB1,
  parameter logic [AW-1:0] A_DAT = 16'hFFB3,
  parameter logic [AW-1:0] A_PU = 16'hFFAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_mode_e      mode,
  input  logic          hw_stby,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  dir_eff,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pu_q
);
  logic [W-1:0] dir_q, dir_d, dat_d, pu_d;
  logic wr_en, hit_dir, hit_dat, hit_pu;
  logic dir_en, dat_en, pu_en;

  assign wr_en   = bus_sel & bus_wr;
  assign hit_dir = wr_en && (bus_addr == A_DIR);
  assign hit_dat = wr_en && (bus_addr == A_DAT);
  assign hit_pu  = wr_en && (bus_addr == A_PU);

  always_comb begin
    dir_en = 1'b0;
    dir_d  = dir_q;
    if (mode == OPM_ADDR) begin
      dir_en = 1'b1;
      dir_d  = '1;
    end else if (hw_stby) begin
      dir_en = 1'b1;
      dir_d  = '0;
    end else if (hit_dir) begin
      dir_en = 1'b1;
      dir_d  = bus_wdata;
    end
    dat_en = hit_dat;
    dat_d  = bus_wdata;
    pu_en  = hit_pu;
    pu_d   = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      pu_q  <= '0;
    end else begin
      if (dir_en) dir_q <= dir_d;
      if (dat_en) dat_q <= dat_d;
      if (pu_en)  pu_q  <= pu_d;
    end
  end

  assign dir_eff = (mode == OPM_ADDR) ? '1 : dir_q;

  assert_hw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby && mode != OPM_ADDR) |=> (dir_q == '0));
  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && !hit_dir && mode != OPM_ADDR) |=> $stable(dir_q));
  assert_data_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dat |=> (dat_q == $past(bus_wdata)));
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OPM_ADDR) |=> (dir_q == '1));
endmodule

// File: rtl/io_pin_mux.sv
module io_pin_mux
  import iop_pkg::*;
#(
  parameter int W = 8
) (
  input  op_mode_e     mode,
  input  logic         hw_stby,
  input  logic [W-1:0] dir_eff,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pu_q,
  input  logic [W-1:0] addr_hi,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  logic use_data;
  assign use_data = (mode == OPM_GPIO);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic src;
    assign src        = use_data ? dat_q[i] : addr_hi[i];
    assign pin_out[i] = dir_eff[i] & src;
    assign pin_oe[i]  = dir_eff[i] & ~hw_stby;
    assign pin_pu[i]  = pu_q[i] & ~dir_eff[i] & ~hw_stby;
  end
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux #(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB1,
  parameter logic [AW-1:0] A_DAT = 16'hFFB3,
  parameter logic [AW-1:0] A_PU = 16'hFFAD
) (
  input  logic          bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  dir_eff,
  input  logic [W-1:0]  dat_q,
  input  logic [W-1:0]  pu_q,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  bus_rdata
);
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == A_DIR)      bus_rdata = '1;
      else if (bus_addr == A_DAT) bus_rdata = (dat_q & dir_eff) | (pin_in & ~dir_eff);
      else if (bus_addr == A_PU)  bus_rdata = pu_q;
    end
  end
endmodule

// File: rtl/gpio_modal_port.sv
module gpio_modal_port
  import iop_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] A_DIR = 16'hFFB1,
  parameter logic [AW-1:0] A_DAT = 16'hFFB3,
  parameter logic [AW-1:0] A_PU = 16'hFFAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_mode,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  addr_hi,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_pu
);
  logic rst_meta, rst_sync_n;
  op_mode_e mode;
  logic [W-1:0] dir_eff, dat_q, pu_q;
  logic sw_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign mode = decode_mode(op_mode);
  // Software standby keeps all state: it enters no logic path.
  assign sw_unused = sw_stby;

  io_port_regs #(.W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PU(A_PU)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode), .hw_stby(hw_stby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dir_eff(dir_eff), .dat_q(dat_q), .pu_q(pu_q)
  );

  io_pin_mux #(.W(W)) u_pins (
    .mode(mode), .hw_stby(hw_stby), .dir_eff(dir_eff), .dat_q(dat_q), .pu_q(pu_q),
    .addr_hi(addr_hi), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  io_read_mux #(.W(W), .AW(AW), .A_DIR(A_DIR), .A_DAT(A_DAT), .A_PU(A_PU)) u_rd (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .dir_eff(dir_eff), .dat_q(dat_q),
    .pu_q(pu_q), .pin_in(pin_in), .bus_rdata(bus_rdata)
  );

  assert_addr_pins_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_mode == 2'd1 && !hw_stby) |-> (pin_oe == '1 && pin_out == addr_hi));
  assert_dir_reads_ones_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_addr == A_DIR) |-> (bus_rdata == '1));
  assert_hw_float_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hw_stby |-> (pin_oe == '0));
  assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_pu & pin_oe) == '0);
  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_modal_port.sv
module tb_gpio_modal_port;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] op_mode;
  logic hw_stby, sw_stby, bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, addr_hi, pin_in, pin_out, pin_oe, pin_pu;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] AD = 16'hFFB1, AT = 16'hFFB3, AP = 16'hFFAD;

  always #5 clk = ~clk;

  gpio_modal_port dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .addr_hi(addr_hi), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  // {mode, wr, addr, wdata, exp_rd, exp_oe, exp_out, exp_pu}
  localparam int NV = 10;
  localparam logic [58:0] VEC [NV] = '{
    {2'd3, 1'b1, AT, 8'h5A, 8'h3C, 8'h00, 8'h00, 8'h00},
    {2'd3, 1'b1, AP, 8'h0F, 8'h0F, 8'h00, 8'h00, 8'h0F},
    {2'd3, 1'b1, AD, 8'hF0, 8'hFF, 8'hF0, 8'h50, 8'h0F},
    {2'd3, 1'b0, AT, 8'h00, 8'h5C, 8'hF0, 8'h50, 8'h0F},
    {2'd2, 1'b0, AD, 8'h00, 8'hFF, 8'hF0, 8'hA0, 8'h0F},
    {2'd2, 1'b1, AD, 8'h3C, 8'hFF, 8'h3C, 8'h24, 8'h03},
    {2'd1, 1'b1, AD, 8'h00, 8'hFF, 8'hFF, 8'hA5, 8'h00},
    {2'd1, 1'b1, 16'h1234, 8'h77, 8'h00, 8'hFF, 8'hA5, 8'h00},
    {2'd2, 1'b0, AT, 8'h00, 8'h5A, 8'hFF, 8'hA5, 8'h00},
    {2'd3, 1'b1, AT, 8'hC3, 8'hC3, 8'hFF, 8'hC3, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_mode = 2'd3; hw_stby = 1'b0; sw_stby = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    addr_hi = 8'hA5; pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state (R6)
    chk("R6 oe", pin_oe, 8'h00);
    chk("R6 pu", pin_pu, 8'h00);
    rd(AT); chk("R6 R11 data read (dir 0)", bus_rdata, 8'h3C);
    rd(AP); chk("R6 pu read", bus_rdata, 8'h00);
    rd(AD); chk("R5 dir read", bus_rdata, 8'hFF);

    // Vector table: R1 R2 R3 R4 R5 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      v = VEC[i];
      @(negedge clk);
      op_mode = v[58:57]; bus_sel = 1'b1; bus_wr = v[56];
      bus_addr = v[55:40]; bus_wdata = v[39:32];
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
      chk($sformatf("R1/R9/R11 vec%0d rdata", i), bus_rdata, v[31:24]);
      chk($sformatf("R2/R3/R4 vec%0d oe", i), pin_oe, v[23:16]);
      chk($sformatf("R2/R3/R4 vec%0d out", i), pin_out, v[15:8]);
      chk($sformatf("R10 vec%0d pu", i), pin_pu, v[7:0]);
    end
    // Now mode 3, dir FF, data C3, pull-up 0F

    // Software standby leaves everything (R8)
    @(negedge clk); sw_stby = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 oe", pin_oe, 8'hFF);
    chk("R8 out", pin_out, 8'hC3);
    chk("R8 pu", pin_pu, 8'h00);
    rd(AT); chk("R8 data", bus_rdata, 8'hC3);
    sw_stby = 1'b0;

    // Hardware standby in general-purpose mode (R7)
    @(negedge clk); hw_stby = 1'b1; #1;
    chk("R7 oe immediate", pin_oe, 8'h00);
    chk("R10 pu off in hw standby", pin_pu, 8'h00);
    @(negedge clk); hw_stby = 1'b0; #1;
    chk("R7 oe after release", pin_oe, 8'h00);
    chk("R10 pu after release", pin_pu, 8'h0F);
    rd(AT); chk("R7 R11 data reads pins", bus_rdata, 8'h3C);

    // Hardware standby in address mode (R7, R2)
    @(negedge clk); op_mode = 2'd1; hw_stby = 1'b1; #1;
    chk("R7 addr mode float", pin_oe, 8'h00);
    @(negedge clk); hw_stby = 1'b0; #1;
    chk("R2 addr mode after release oe", pin_oe, 8'hFF);
    chk("R2 addr mode out", pin_out, 8'hA5);

    // Mixed mode after hw standby: dir was cleared (R7, R3)
    wr(AD, 8'h0F);
    @(negedge clk); op_mode = 2'd2; hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0; #1;
    chk("R7 mixed mode dir cleared", pin_oe, 8'h00);

    // Combinational read and idle bus (R12)
    @(negedge clk); bus_sel = 1'b0; bus_addr = AP; #1;
    chk("R12 idle bus", bus_rdata, 8'h00);
    bus_sel = 1'b1; #1;
    chk("R12 same-cycle read", bus_rdata, 8'h0F);
    bus_addr = 16'hFFB2; #1;
    chk("R1 unmapped read", bus_rdata, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule